// File: doc/BRIEF.md
# NAND Flash Command Interface Controller

This block is the device side of a NAND flash bus. It decodes command, address and data bus cycles. Each bus cycle is presented as a one-clock write strobe, marked as a command cycle, an address cycle or a data cycle. Supported flows are page program with sequential and random data input, block erase, status read and reset. The storage behind the flows is a small behavioural array held in registers. A busy period follows each program or erase, and its length in clock cycles is set by a parameter. A ready/busy output and a status byte report progress and the pass/fail result.

Program flow: a setup code, two column address cycles, three row address cycles, data bytes into a page buffer, then a confirm code. The page buffer covers a main area followed by a spare area. A random-input code followed by two column cycles moves the buffer write pointer during data input. Erase flow: a setup code, three row cycles, then a confirm code. The row carries the page index in its low bits and the block index directly above it. Erase selects by block only.

Top module: `nand_ci`

## Requirements
- R1: After reset, rb_o is 1, the array reads fully erased (all bytes 0xFF), and a status read returns 0x40.
- R2: Program: command 0x80, then five address cycles (column low, column high, row bytes 0, 1, 2), data cycles, then command 0x10. rb_o is 0 from the clock after the 0x10 cycle, for exactly PROG_CYC cycles.
- R3: Erase: command 0x60, then three row address cycles, then command 0xD0. rb_o is 0 from the clock after the 0xD0 cycle, for exactly ERASE_CYC cycles.
- R4: After command 0x70, each re_i strobe loads io_o with the status byte. In that byte, bit 6 is ready (0 while busy) and bit 0 is fail, and every other bit is 0.
- R5: While busy, every command except 0x70 and 0xFF is ignored. The busy length is unchanged and no further operation follows.
- R6: Programming stores old AND new in every loaded byte. If a loaded byte has a 1 where the array holds 0, status bit 0 is set after the operation; otherwise it is clear.
- R7: Erase sets every byte of every page in the block selected by row bits [PG_W+BLK_W-1:PG_W] to 0xFF. The page bits are ignored, and other blocks are untouched.
- R8: During data input, command 0x85 followed by two column cycles moves the write pointer to that column. Bytes already loaded are kept.
- R9: Page-buffer bytes not loaded in a program leave the array unchanged and never cause a failure. Data bytes advance the column by one.
- R10: Command 0xFF aborts a busy operation. rb_o is 1 in the next cycle, the status reads 0x40, and the array is not modified.
- R11: Columns 0 to MAIN_BYTES+SPARE_BYTES-1 (spare area included) are writable. Data at any column at or above that limit is dropped, with no aliasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | One-cycle bus write strobe |
| cmd_i | input | 1 | Strobed cycle is a command |
| addr_i | input | 1 | Strobed cycle is an address byte |
| re_i | input | 1 | One-cycle read strobe |
| io_i | input | 8 | Bus byte written by host |
| io_o | output | 8 | Bus byte returned to host |
| rb_o | output | 1 | Ready (1) / busy (0) |

## Verification
The embedded properties check several things on every cycle:
- the busy start after a program or erase confirm;
- that a non-status, non-reset command leaves a busy operation running;
- the immediate return to ready on reset;
- the zero bits of every status byte;
- the one-step pointer advance;
- that a program commit never turns a 0 into a 1;
- that an erase commit leaves the addressed page all ones.

Only the directed scenarios can show the exact busy lengths and the pass/fail codes. The array contents are probed through those pass/fail codes. This covers pointer moves, data kept across random input, the spare area, dropped out-of-range columns, block-only erase selection and an aborted program leaving the array intact.

// File: rtl/nand_ci_pkg.sv
package nand_ci_pkg;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_RAND_IN     = 8'h85;
  localparam logic [7:0] OP_PROG_GO     = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PADDR,
    ST_PDATA,
    ST_RADDR,
    ST_EADDR,
    ST_EWAIT,
    ST_BUSY
  } ci_state_e;
endpackage

// File: rtl/nand_ci_busy_timer.sv
module nand_ci_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             clr_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (load_i)             cnt_q <= val_i;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == CNT_W'(1));

  // R2: a terminal count is followed by an idle counter unless reloaded
  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i && !clr_i |=> !done_o);
endmodule

// File: rtl/nand_ci_page_buf.sv
module nand_ci_page_buf #(
  parameter int PAGE_BYTES = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    set_ptr_i,
  input  logic [15:0]             ptr_i,
  input  logic                    wr_i,
  input  logic [7:0]              data_i,
  output logic [PAGE_BYTES*8-1:0] page_o,
  output logic [PAGE_BYTES-1:0]   mask_o
);
  logic [15:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= '0;
    else if (clr_i)             ptr_q <= '0;
    else if (set_ptr_i)         ptr_q <= ptr_i;
    else if (wr_i)              ptr_q <= ptr_q + 16'd1;
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_o[i*8 +: 8] <= 8'hFF;
        mask_o[i]        <= 1'b0;
      end else if (clr_i) begin
        page_o[i*8 +: 8] <= 8'hFF;
        mask_o[i]        <= 1'b0;
      end else if (wr_i && !set_ptr_i && ptr_q == 16'(i)) begin
        page_o[i*8 +: 8] <= data_i;
        mask_o[i]        <= 1'b1;
      end
    end
  end

  // R8 / R9: each data byte advances the column by exactly one
  p_ptr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !set_ptr_i && !clr_i |=> ptr_q == $past(ptr_q) + 16'd1);
endmodule

// File: rtl/nand_ci_array.sv
module nand_ci_array #(
  parameter int PAGE_BYTES    = 10,
  parameter int PAGES_PER_BLK = 4,
  parameter int BLOCKS        = 4,
  localparam int PW           = PAGE_BYTES * 8,
  localparam int PG_W         = $clog2(PAGES_PER_BLK),
  localparam int BLK_W        = $clog2(BLOCKS),
  localparam int IDX_W        = PG_W + BLK_W,
  localparam int NPG          = PAGES_PER_BLK * BLOCKS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PW-1:0]    buf_i,
  input  logic             prog_i,
  input  logic             erase_i,
  output logic [PW-1:0]    cur_o
);
  logic [PW-1:0] mem_q [NPG];
  logic [BLK_W-1:0] blk;

  assign blk   = idx_i[PG_W +: BLK_W];
  assign cur_o = mem_q[idx_i];

  for (genvar p = 0; p < NPG; p++) begin : g_page
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            mem_q[p] <= '1;
      else if (prog_i && idx_i == IDX_W'(p))                  mem_q[p] <= mem_q[p] & buf_i;
      else if (erase_i && blk == BLK_W'(p / PAGES_PER_BLK))   mem_q[p] <= '1;
    end
  end

  // R6: a program commit never sets a bit that was clear
  p_prog_clear_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i && !erase_i |=> (cur_o & ~$past(cur_o)) == '0);
  // R7: an erase commit leaves the addressed page all ones
  p_erase_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i && !prog_i |=> &cur_o);
endmodule

// File: rtl/nand_ci.sv
module nand_ci
  import nand_ci_pkg::*;
#(
  parameter int MAIN_BYTES    = 8,
  parameter int SPARE_BYTES   = 2,
  parameter int PAGES_PER_BLK = 4,
  parameter int BLOCKS        = 4,
  parameter int PROG_CYC      = 12,
  parameter int ERASE_CYC     = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       cmd_i,
  input  logic       addr_i,
  input  logic       re_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       rb_o
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int PW         = PAGE_BYTES * 8;
  localparam int IDX_W      = $clog2(PAGES_PER_BLK) + $clog2(BLOCKS);
  localparam int MAX_CYC    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  ci_state_e        state_q;
  logic [2:0]       acnt_q;
  logic [7:0]       col_lo_q;
  logic [IDX_W-1:0] idx_q;
  logic             stat_mode_q, fail_q, pend_fail_q, op_erase_q;
  logic             cmd_we, addr_we, data_we, busy, done, abort;
  logic             start_prog, start_erase, commit, col_set, prog_fail;
  logic [PW-1:0]    page_buf, cur_page;
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0]       status;

  assign cmd_we  = we_i & cmd_i;
  assign addr_we = we_i & addr_i & ~cmd_i;
  assign data_we = we_i & ~cmd_i & ~addr_i;
  assign busy    = (state_q == ST_BUSY);
  assign abort   = cmd_we && io_i == OP_RESET;
  assign rb_o    = ~busy;

  assign start_prog  = !busy && cmd_we && io_i == OP_PROG_GO && state_q == ST_PDATA;
  assign start_erase = !busy && cmd_we && io_i == OP_ERASE_GO && state_q == ST_EWAIT;
  assign commit      = busy && done && !abort;
  assign col_set     = addr_we && acnt_q == 3'd1 && (state_q == ST_PADDR || state_q == ST_RADDR);
  assign status      = {1'b0, ~busy, 5'b0, fail_q};

  // fail only where a loaded byte asks for a 1 over a programmed 0
  always_comb begin
    prog_fail = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++)
      if (mask[i]) prog_fail |= |(page_buf[i*8 +: 8] & ~cur_page[i*8 +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      acnt_q      <= '0;
      col_lo_q    <= '0;
      idx_q       <= '0;
      stat_mode_q <= 1'b0;
      fail_q      <= 1'b0;
      pend_fail_q <= 1'b0;
      op_erase_q  <= 1'b0;
    end else if (abort) begin
      state_q     <= ST_IDLE;
      stat_mode_q <= 1'b0;
      fail_q      <= 1'b0;
    end else if (busy) begin
      if (cmd_we && io_i == OP_STATUS) stat_mode_q <= 1'b1;
      if (done) begin
        state_q <= ST_IDLE;
        fail_q  <= pend_fail_q;
      end
    end else if (cmd_we) begin
      stat_mode_q <= (io_i == OP_STATUS);
      acnt_q      <= '0;
      unique case (io_i)
        OP_PROG_SETUP:  state_q <= ST_PADDR;
        OP_RAND_IN:     state_q <= (state_q == ST_PDATA) ? ST_RADDR : ST_IDLE;
        OP_ERASE_SETUP: state_q <= ST_EADDR;
        OP_STATUS:      state_q <= state_q;
        OP_PROG_GO, OP_ERASE_GO: begin
          if (start_prog || start_erase) begin
            state_q     <= ST_BUSY;
            op_erase_q  <= start_erase;
            pend_fail_q <= start_prog && prog_fail;
            fail_q      <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default:        state_q <= ST_IDLE;
      endcase
    end else if (addr_we) begin
      acnt_q <= acnt_q + 3'd1;
      case (state_q)
        ST_PADDR: begin
          if (acnt_q == 3'd0) col_lo_q <= io_i;
          if (acnt_q == 3'd2) idx_q <= io_i[IDX_W-1:0];
          if (acnt_q == 3'd4) state_q <= ST_PDATA;
        end
        ST_RADDR: begin
          if (acnt_q == 3'd0) col_lo_q <= io_i;
          if (acnt_q == 3'd1) state_q <= ST_PDATA;
        end
        ST_EADDR: begin
          if (acnt_q == 3'd0) idx_q <= io_i[IDX_W-1:0];
          if (acnt_q == 3'd2) state_q <= ST_EWAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   io_o <= 8'h00;
    else if (re_i) io_o <= stat_mode_q ? status : 8'h00;
  end

  nand_ci_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_prog || start_erase),
    .val_i  (start_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC)),
    .clr_i  (abort),
    .done_o (done)
  );

  nand_ci_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!busy && cmd_we && io_i == OP_PROG_SETUP),
    .set_ptr_i (col_set),
    .ptr_i     ({io_i, col_lo_q}),
    .wr_i      (data_we && state_q == ST_PDATA),
    .data_i    (io_i),
    .page_o    (page_buf),
    .mask_o    (mask)
  );

  nand_ci_array #(
    .PAGE_BYTES    (PAGE_BYTES),
    .PAGES_PER_BLK (PAGES_PER_BLK),
    .BLOCKS        (BLOCKS)
  ) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (idx_q),
    .buf_i   (page_buf),
    .prog_i  (commit && !op_erase_q),
    .erase_i (commit && op_erase_q),
    .cur_o   (cur_page)
  );

  p_prog_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_prog && !abort |=> !rb_o);
  p_erase_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_erase && !abort |=> !rb_o);
  p_status_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> io_o[7] == 1'b0 && io_o[5:1] == 5'b0);
  p_ignore_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done && cmd_we && io_i != OP_RESET |=> !rb_o);
  p_reset_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> rb_o && !fail_q);
endmodule

// File: tb/sim_nand_ci.sv
module sim_nand_ci;
  localparam int PROG_N  = 12;
  localparam int ERASE_N = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, cmd = 1'b0, addr = 1'b0, re = 1'b0;
  logic [7:0] io = 8'h00;
  logic [7:0] io_o;
  logic rb_o;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  nand_ci #(.PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .cmd_i(cmd), .addr_i(addr),
    .re_i(re), .io_i(io), .io_o(io_o), .rb_o(rb_o)
  );

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endfunction

  task automatic bus(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk); we = 1'b1; cmd = c; addr = a; io = v;
    @(negedge clk); we = 1'b0; cmd = 1'b0; addr = 1'b0;
  endtask

  task automatic wait_rb(output int n);
    n = 0;
    while (!rb_o && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic rd_status(output logic [7:0] s);
    bus(1'b1, 1'b0, 8'h70);
    @(negedge clk); re = 1'b1;
    @(negedge clk); re = 1'b0;
    s = io_o;
  endtask

  task automatic open_prog(input logic [7:0] row, input logic [7:0] col);
    bus(1'b1, 1'b0, 8'h80);
    bus(1'b0, 1'b1, col); bus(1'b0, 1'b1, 8'h00);
    bus(1'b0, 1'b1, row); bus(1'b0, 1'b1, 8'h00); bus(1'b0, 1'b1, 8'h00);
  endtask

  // single-byte program, returns status after completion
  task automatic prog_byte(input logic [7:0] row, input logic [7:0] col,
                           input logic [7:0] d, output logic [7:0] s);
    int n;
    open_prog(row, col);
    bus(1'b0, 1'b0, d);
    bus(1'b1, 1'b0, 8'h10);
    wait_rb(n);
    rd_status(s);
  endtask

  task automatic erase_blk(input logic [7:0] row, output int n);
    bus(1'b1, 1'b0, 8'h60);
    bus(1'b0, 1'b1, row); bus(1'b0, 1'b1, 8'h00); bus(1'b0, 1'b1, 8'h00);
    bus(1'b1, 1'b0, 8'hD0);
    wait_rb(n);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R1 rb after reset", rb_o, 1);
    rd_status(s);
    chk("R1 status after reset", s, 8'h40);
    prog_byte(8'd6, 8'd4, 8'hFF, s);
    chk("R1 array erased at reset", s, 8'h40);
  endtask

  task automatic t_program;
    logic [7:0] s;
    int n;
    open_prog(8'd1, 8'd0);
    bus(1'b0, 1'b0, 8'hA5);
    bus(1'b0, 1'b0, 8'h3C);
    bus(1'b1, 1'b0, 8'h10);
    chk("R2 busy after confirm", rb_o, 0);
    wait_rb(n);
    chk("R2 program busy length", n, PROG_N);
    rd_status(s);
    chk("R6 first program passes", s, 8'h40);
    prog_byte(8'd1, 8'd0, 8'h25, s);
    chk("R6 clearing more bits passes", s, 8'h40);
    prog_byte(8'd1, 8'd0, 8'hA5, s);
    chk("R6 setting a cleared bit fails", s, 8'h41);
    prog_byte(8'd1, 8'd1, 8'h3C, s);
    chk("R9 untouched byte and second byte kept", s, 8'h40);
  endtask

  task automatic t_random;
    logic [7:0] s;
    int n;
    open_prog(8'd2, 8'd0);
    bus(1'b0, 1'b0, 8'h11);
    bus(1'b1, 1'b0, 8'h85);
    bus(1'b0, 1'b1, 8'd5); bus(1'b0, 1'b1, 8'h00);
    bus(1'b0, 1'b0, 8'h22);
    bus(1'b1, 1'b0, 8'h10);
    wait_rb(n);
    rd_status(s);
    chk("R8 random input program passes", s, 8'h40);
    prog_byte(8'd2, 8'd5, 8'h33, s);
    chk("R8 byte landed at moved column", s, 8'h41);
    prog_byte(8'd2, 8'd0, 8'h13, s);
    chk("R8 earlier byte kept", s, 8'h41);
    prog_byte(8'd2, 8'd3, 8'hFF, s);
    chk("R9 unloaded column unchanged", s, 8'h40);
  endtask

  task automatic t_columns;
    logic [7:0] s;
    int n;
    open_prog(8'd3, 8'd9);
    bus(1'b0, 1'b0, 8'h0F);
    bus(1'b1, 1'b0, 8'h85);
    bus(1'b0, 1'b1, 8'd16); bus(1'b0, 1'b1, 8'h00);
    bus(1'b0, 1'b0, 8'h00);
    bus(1'b1, 1'b0, 8'h10);
    wait_rb(n);
    prog_byte(8'd3, 8'd9, 8'hFF, s);
    chk("R11 spare column written", s, 8'h41);
    prog_byte(8'd3, 8'd0, 8'hFF, s);
    chk("R11 out-of-range column dropped", s, 8'h40);
  endtask

  task automatic t_erase;
    logic [7:0] s;
    int n;
    prog_byte(8'd4, 8'd0, 8'h0F, s);
    bus(1'b1, 1'b0, 8'h60);
    bus(1'b0, 1'b1, 8'd3); bus(1'b0, 1'b1, 8'h00); bus(1'b0, 1'b1, 8'h00);
    bus(1'b1, 1'b0, 8'hD0);
    chk("R3 busy after erase confirm", rb_o, 0);
    rd_status(s);
    chk("R4 status while busy", s, 8'h00);
    wait_rb(n);
    chk("R3 erase busy length", n, ERASE_N - 4);
    rd_status(s);
    chk("R4 status after erase", s, 8'h40);
    prog_byte(8'd1, 8'd0, 8'hFF, s);
    chk("R7 page bits ignored, block erased", s, 8'h40);
    prog_byte(8'd4, 8'd0, 8'hFF, s);
    chk("R7 other block untouched", s, 8'h41);
  endtask

  task automatic t_ignore;
    logic [7:0] s;
    int n;
    open_prog(8'd5, 8'd0);
    bus(1'b0, 1'b0, 8'hF0);
    bus(1'b1, 1'b0, 8'h10);
    bus(1'b1, 1'b0, 8'h60);
    bus(1'b0, 1'b1, 8'd5); bus(1'b0, 1'b1, 8'h00); bus(1'b0, 1'b1, 8'h00);
    bus(1'b1, 1'b0, 8'hD0);
    wait_rb(n);
    chk("R5 busy not extended", n, PROG_N - 10);
    repeat (5) @(negedge clk);
    chk("R5 no erase follows", rb_o, 1);
    prog_byte(8'd5, 8'd0, 8'hFF, s);
    chk("R5 page not erased by ignored command", s, 8'h41);
  endtask

  task automatic t_abort;
    logic [7:0] s;
    open_prog(8'd8, 8'd0);
    bus(1'b0, 1'b0, 8'h00);
    bus(1'b1, 1'b0, 8'h10);
    bus(1'b1, 1'b0, 8'hFF);
    chk("R10 ready right after reset", rb_o, 1);
    rd_status(s);
    chk("R10 status after abort", s, 8'h40);
    prog_byte(8'd8, 8'd0, 8'hFF, s);
    chk("R10 array not modified", s, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_random();
    t_columns();
    t_erase();
    t_ignore();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule